// File: doc/BRIEF.md
# Polarity-Selectable External Interrupt Detector

This block watches five asynchronous external request pins and latches a sticky flag for each pin when that pin makes a transition in the direction chosen for it. Every pin first passes through a two-stage synchroniser. The block then compares the polarity-adjusted current sample with the polarity-adjusted previous sample. Because of this, a change of the polarity bit while the pin holds a steady level can look like an edge, and the block reproduces that case exactly.

Software sees three small registers through one access port: polarity, flag and enable. Each register accepts a plain write, a clear of the bits written as 1, and a set of the bits written as 1. The safe reconfiguration sequence is to disable the source, change its polarity, clear its flag and re-enable it. Each step is one separate access. The flags, gated by the enables, form a pending vector for a downstream priority controller.

Each source's flag is a two-state machine, FLAG_IDLE and FLAG_RAISED. It has three named transitions. T_EDGE goes from either state to FLAG_RAISED on a detected edge. T_SW_RAISE goes from FLAG_IDLE to FLAG_RAISED on a software write or set of a 1. T_SW_DROP goes from FLAG_RAISED to FLAG_IDLE on a software write of 0 or a clear of 1, and only when no edge occurs in the same cycle.

Top module: `xirq_edge_unit`

## Requirements
- R1: There are five sources. Bit n of every register, of `ext_pin` and of `pending` belongs to source n, and activity on one source leaves the other sources' flags untouched.
- R2: A transition on `ext_pin[n]` placed between clock edges first appears in the flag on the third rising clock edge after it, and not on the second.
- R3: A pin held at a constant level never sets its flag once the flag has been cleared.
- R4: Polarity bit n (register select 0) set to 1 makes source n respond to low-to-high transitions, and set to 0 makes it respond to high-to-low transitions. A transition in the other direction leaves the flag clear.
- R5: With the pin steady, changing its polarity bit from 1 to 0 while the pin is low, or from 0 to 1 while the pin is high, sets the flag on the clock edge after the write. The reverse changes do not set the flag.
- R6: `reg_sel` 0 selects polarity, 1 selects flags and 2 selects enables. `reg_sel` 3 reads as zero and ignores writes. `reg_op` 0 loads `reg_wdata`, 1 clears the bits written as 1, 2 sets the bits written as 1, and 3 changes nothing. A write takes effect on the clock edge where `reg_we` is high.
- R7: A detected edge sets the flag even while the source is disabled. `pending[n]` equals flag n AND enable n.
- R8: When a software clear of a flag and a detected edge for that flag fall on the same clock edge, the flag ends set.
- R9: After reset all three registers read zero and `pending` is zero.
- R10: `reg_rdata` presents the selected register combinationally, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin | input | 5 | Asynchronous external request pins |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select (0 polarity, 1 flag, 2 enable) |
| reg_op | input | 2 | Access kind (0 write, 1 clear, 2 set, 3 none) |
| reg_wdata | input | 5 | Write data or bit mask |
| reg_rdata | output | 5 | Selected register contents |
| pending | output | 5 | Enabled flags to the priority controller |

## Verification
Two functions can hit the same flag bit on the same clock edge: a software clear from the register port and a hardware edge from the detector. The bench presets the flag by software, raises the pin, and counts synchroniser cycles so that the clear strobe lands exactly on the edge where the detector fires. The flag must read set afterwards, and a later clear on its own must then drop it. A related case is a polarity write that creates an edge from a steady pin. This is judged by reading the flag one edge after the write, when it must still be clear, and again one edge later, when it must be set.

// File: rtl/xirq_pkg.sv
package xirq_pkg;

    typedef enum logic [1:0] {
        SEL_POL  = 2'd0,
        SEL_FLAG = 2'd1,
        SEL_EN   = 2'd2,
        SEL_NONE = 2'd3
    } xirq_sel_e;

    typedef enum logic [1:0] {
        OP_WRITE = 2'd0,
        OP_CLR   = 2'd1,
        OP_SET   = 2'd2,
        OP_NOP   = 2'd3
    } xirq_op_e;

    typedef enum logic {
        FLAG_IDLE   = 1'b0,
        FLAG_RAISED = 1'b1
    } xirq_flag_e;

    // Next value of one register bit under a given access kind.
    function automatic logic apply_op(input xirq_op_e op, input logic cur, input logic w);
        logic nxt;
        unique case (op)
            OP_WRITE: nxt = w;
            OP_CLR:   nxt = cur & ~w;
            OP_SET:   nxt = cur | w;
            OP_NOP:   nxt = cur;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/xirq_sync.sv
module xirq_sync #(
    parameter int WIDTH  = 5,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= async_in;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/xirq_ctlreg.sv
module xirq_ctlreg
    import xirq_pkg::*;
#(
    parameter int WIDTH = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit,
    input  xirq_op_e         op,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] q_d;

    always_comb begin
        q_d = q;
        if (hit) begin
            for (int b = 0; b < WIDTH; b++) q_d[b] = apply_op(op, q[b], wdata[b]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= q_d;
    end

    assert_clear_drops_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && op == OP_CLR) |=> ((q & $past(wdata)) == '0));
    assert_set_raises_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && op == OP_SET) |=> ((q & $past(wdata)) == $past(wdata)));
    assert_idle_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit || op == OP_NOP) |=> $stable(q));
endmodule

// File: rtl/xirq_channel.sv
module xirq_channel
    import xirq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     pin_s,
    input  logic     pol,
    input  logic     sw_hit,
    input  xirq_op_e op,
    input  logic     wbit,
    output logic     flag,
    output logic     edge_det
);
    xirq_flag_e state_q, state_d;
    logic adj_cur, adj_prev_q;
    logic sw_raise, sw_drop;

    // Polarity-adjusted sample: 1 means "at the level an edge ends on".
    assign adj_cur  = pin_s ~^ pol;
    assign edge_det = adj_cur & ~adj_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) adj_prev_q <= 1'b1;  // matches pin 0, polarity 0
        else        adj_prev_q <= adj_cur;
    end

    assign sw_raise = sw_hit && wbit && (op == OP_WRITE || op == OP_SET);
    assign sw_drop  = sw_hit && ((op == OP_WRITE && !wbit) || (op == OP_CLR && wbit));

    // Next-state process: T_EDGE, T_SW_RAISE, T_SW_DROP.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_IDLE:   if (edge_det || sw_raise) state_d = FLAG_RAISED;
            FLAG_RAISED: if (!edge_det && sw_drop) state_d = FLAG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLAG_IDLE;
        else        state_q <= state_d;
    end

    // Output process.
    always_comb begin
        flag = 1'b0;
        unique case (state_q)
            FLAG_IDLE:   flag = 1'b0;
            FLAG_RAISED: flag = 1'b1;
        endcase
    end

    assert_edge_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        edge_det |=> flag);
    assert_flag_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(edge_det || sw_raise));
    assert_level_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(pin_s) && $stable(pol)) |-> !edge_det);
endmodule

// File: rtl/xirq_edge_unit.sv
module xirq_edge_unit
    import xirq_pkg::*;
#(
    parameter int NUM_SRC     = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] ext_pin,
    input  logic               reg_we,
    input  logic [1:0]         reg_sel,
    input  logic [1:0]         reg_op,
    input  logic [NUM_SRC-1:0] reg_wdata,
    output logic [NUM_SRC-1:0] reg_rdata,
    output logic [NUM_SRC-1:0] pending
);
    xirq_sel_e          sel;
    xirq_op_e           op;
    logic [NUM_SRC-1:0] pin_s, pol_q, en_q, flags, edges;
    logic               hit_pol, hit_flag, hit_en;

    assign sel      = xirq_sel_e'(reg_sel);
    assign op       = xirq_op_e'(reg_op);
    assign hit_pol  = reg_we && sel == SEL_POL;
    assign hit_flag = reg_we && sel == SEL_FLAG;
    assign hit_en   = reg_we && sel == SEL_EN;

    xirq_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(ext_pin), .sync_out(pin_s)
    );

    xirq_ctlreg #(.WIDTH(NUM_SRC)) u_pol (
        .clk(clk), .rst_n(rst_n), .hit(hit_pol), .op(op), .wdata(reg_wdata), .q(pol_q)
    );

    xirq_ctlreg #(.WIDTH(NUM_SRC)) u_en (
        .clk(clk), .rst_n(rst_n), .hit(hit_en), .op(op), .wdata(reg_wdata), .q(en_q)
    );

    for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
        xirq_channel u_ch (
            .clk(clk), .rst_n(rst_n), .pin_s(pin_s[n]), .pol(pol_q[n]),
            .sw_hit(hit_flag), .op(op), .wbit(reg_wdata[n]),
            .flag(flags[n]), .edge_det(edges[n])
        );
    end

    assign pending = flags & en_q;

    always_comb begin
        unique case (sel)
            SEL_POL:  reg_rdata = pol_q;
            SEL_FLAG: reg_rdata = flags;
            SEL_EN:   reg_rdata = en_q;
            SEL_NONE: reg_rdata = '0;
        endcase
    end

    assert_no_pending_while_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pending & ~en_q) == '0);
    assert_pending_follows_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((edges & en_q) != '0 && !(reg_we && sel == SEL_EN)) |=> ((pending & $past(edges & en_q)) == $past(edges & en_q)));
    assert_pins_independent_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_we && edges == '0) |=> $stable(flags));
endmodule

// File: tb/xirq_edge_unit_test.sv
module xirq_edge_unit_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] ext_pin = '0;
    logic       reg_we = 1'b0;
    logic [1:0] reg_sel = '0;
    logic [1:0] reg_op = '0;
    logic [4:0] reg_wdata = '0;
    logic [4:0] reg_rdata, pending;
    int n_checks = 0, n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    xirq_edge_unit uut (
        .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .reg_we(reg_we),
        .reg_sel(reg_sel), .reg_op(reg_op), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .pending(pending)
    );

    typedef struct packed {
        logic [1:0] sel;
        logic [1:0] op;
        logic [4:0] w;
        logic [1:0] chk;
        logic [4:0] exp;
    } vec_t;

    localparam vec_t TABLE [8] = '{
        '{2'd2, 2'd0, 5'b10110, 2'd2, 5'b10110},
        '{2'd2, 2'd1, 5'b00110, 2'd2, 5'b10000},
        '{2'd2, 2'd2, 5'b00011, 2'd2, 5'b10011},
        '{2'd2, 2'd3, 5'b11111, 2'd2, 5'b10011},
        '{2'd3, 2'd0, 5'b11111, 2'd2, 5'b10011},
        '{2'd1, 2'd2, 5'b01001, 2'd1, 5'b01001},
        '{2'd1, 2'd1, 5'b00001, 2'd1, 5'b01000},
        '{2'd1, 2'd0, 5'b10100, 2'd1, 5'b10100}
    };

    task automatic chk(input string tag, input logic [4:0] act, input logic [4:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // Called at a negedge; returns at the negedge after the write edge.
    task automatic reg_access(input logic [1:0] s, input logic [1:0] o, input logic [4:0] w);
        reg_we = 1'b1; reg_sel = s; reg_op = o; reg_wdata = w;
        @(negedge clk);
        reg_we = 1'b0; reg_op = 2'd3; reg_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] s, output logic [4:0] v);
        reg_sel = s;
        #1;
        v = reg_rdata;
    endtask

    task automatic wait_cycles(input int k);
        for (int i = 0; i < k; i++) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [4:0] v;
        wait_cycles(3);
        // R9 reset state
        rd(2'd0, v); chk("R9 polarity after reset", v, '0);
        rd(2'd1, v); chk("R9 flags after reset", v, '0);
        rd(2'd2, v); chk("R9 enables after reset", v, '0);
        chk("R9 pending after reset", pending, '0);
        rst_n = 1'b1;
        wait_cycles(2);

        // R6 / R10 table walk: pins low, polarity 0, so no edges occur
        for (int i = 0; i < 8; i++) begin
            reg_access(TABLE[i].sel, TABLE[i].op, TABLE[i].w);
            rd(TABLE[i].chk, v);
            chk($sformatf("R6 table entry %0d", i), v, TABLE[i].exp);
        end
        chk("R7 pending is flag AND enable", pending, 5'b10000);
        rd(2'd3, v); chk("R6 select 3 reads zero", v, '0);
        reg_access(2'd1, 2'd0, 5'b00000);
        reg_access(2'd2, 2'd0, 5'b00000);

        // R2 / R4 rising edge on source 0 with three-edge latency
        reg_access(2'd0, 2'd2, 5'b00001);
        rd(2'd1, v); chk("R5 0->1 polarity with pin low gives nothing", v, '0);
        ext_pin[0] = 1'b1;
        wait_cycles(2);
        rd(2'd1, v); chk("R2 flag not yet set after two edges", v, '0);
        wait_cycles(1);
        rd(2'd1, v); chk("R2 R4 R1 rising edge sets only flag 0", v, 5'b00001);
        chk("R7 pending stays low while disabled", pending, '0);
        reg_access(2'd2, 2'd2, 5'b00001);
        chk("R7 enabling exposes pending", pending, 5'b00001);
        reg_access(2'd2, 2'd0, 5'b00000);
        reg_access(2'd1, 2'd1, 5'b00001);
        wait_cycles(4);
        rd(2'd1, v); chk("R3 steady high level does not re-raise", v, '0);
        ext_pin[0] = 1'b0;
        wait_cycles(4);
        rd(2'd1, v); chk("R4 falling edge ignored under rising polarity", v, '0);

        // R4 falling polarity on source 1
        ext_pin[1] = 1'b1;
        wait_cycles(4);
        rd(2'd1, v); chk("R4 rising edge ignored under falling polarity", v, '0);
        ext_pin[1] = 1'b0;
        wait_cycles(3);
        rd(2'd1, v); chk("R4 falling edge sets flag 1", v, 5'b00010);
        reg_access(2'd1, 2'd0, 5'b00000);

        // R5 polarity change with steady pin on source 2 (pin low)
        reg_access(2'd0, 2'd2, 5'b00100);
        wait_cycles(2);
        rd(2'd1, v); chk("R5 0->1 with low pin leaves flag clear", v, '0);
        reg_access(2'd0, 2'd1, 5'b00100);
        rd(2'd1, v); chk("R5 flag clear right after 1->0 write edge", v, '0);
        wait_cycles(1);
        rd(2'd1, v); chk("R5 1->0 with low pin raises flag 2", v, 5'b00100);
        reg_access(2'd1, 2'd0, 5'b00000);

        // R5 on source 3 with pin high
        ext_pin[3] = 1'b1;
        wait_cycles(4);
        rd(2'd1, v); chk("R5 setup: rising ignored on source 3", v, '0);
        reg_access(2'd0, 2'd2, 5'b01000);
        wait_cycles(1);
        rd(2'd1, v); chk("R5 0->1 with high pin raises flag 3", v, 5'b01000);
        reg_access(2'd1, 2'd0, 5'b00000);
        reg_access(2'd0, 2'd1, 5'b01000);
        wait_cycles(1);
        rd(2'd1, v); chk("R5 1->0 with high pin leaves flag clear", v, '0);

        // R8 clear and edge on the same clock edge, source 4
        reg_access(2'd0, 2'd2, 5'b10000);
        reg_access(2'd1, 2'd2, 5'b10000);
        ext_pin[4] = 1'b1;
        wait_cycles(2);
        reg_access(2'd1, 2'd1, 5'b10000);  // lands on the third edge
        rd(2'd1, v); chk("R8 flag survives clear colliding with edge", v, 5'b10000);
        reg_access(2'd1, 2'd1, 5'b10000);
        rd(2'd1, v); chk("R8 lone clear afterwards drops flag", v, '0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule